// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This unit carries out the wide arithmetic of a small 8-bit processor core: stepping a 16-bit register pair up or down, adding a register pair into the HL pair, and adding a signed byte offset to the stack pointer. The result can go back to the stack pointer or into HL. The register file supplies the current values of the four pairs and the offset byte. The unit returns the 16-bit result, the code of the pair that must take it, and a value for each of the four condition flags (zero, subtract, half-carry, carry). Each flag has its own write enable.

The flag register is shared with the 8-bit ALU. For that reason the unit never drives a flag it does not mean to change. It lowers that flag's enable, and the flag register keeps its old bit. Each operation is taken in the cycle in which `opValid` is high. The registered outcome appears one clock later with a single-cycle `resValid` pulse.

Top module: `arith16_unit`

## Requirements
- R1: After reset is released, and before any operation is taken, `resValid`, `result`, `resDest` and all four flag enables are zero.
- R2: An operation taken with `opValid` high in one cycle appears on the outputs in the following cycle, together with a one-cycle `resValid` pulse. Without an accepted operation, `resValid` stays low.
- R3: `opSel` 0 increments the pair selected by `pairCode` (opcode bits [5:4]; 0 = BC, 1 = DE, 2 = HL, 3 = SP) modulo 2^16, so 0xFFFF becomes 0x0000. `resDest` equals `pairCode`.
- R4: `opSel` 1 decrements the selected pair modulo 2^16, so 0x0000 becomes 0xFFFF. `resDest` equals `pairCode`.
- R5: Increment and decrement leave all four flag enables low.
- R6: `opSel` 2 adds the selected pair to HL and sets `resDest` to 2 (HL). Carry is the carry out of bit 15 of the sum.
- R7: For `opSel` 2, subtract is written as 0 and half-carry is written as the carry out of bit 11. Zero is not written.
- R8: `opSel` 3 and 4 add the offset, sign-extended to 16 bits, to SP. `resDest` is 3 (SP) for `opSel` 3 and 2 (HL) for `opSel` 4.
- R9: For `opSel` 3 and 4, carry is the carry out of bit 7 of SP's low byte plus the offset taken as an unsigned byte. Half-carry is the carry out of bit 3 of that same sum.
- R10: For `opSel` 3 and 4, zero and subtract are both written as 0.
- R11: `opSel` values 5, 6 and 7 are not recognised. Such a request produces no `resValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Take an operation this cycle |
| opSel | input | 3 | Operation code (0 inc, 1 dec, 2 add pair to HL, 3 SP+offset to SP, 4 SP+offset to HL) |
| pairCode | input | 2 | Pair select, opcode bits [5:4] |
| pairBc | input | ADDR_W | Current BC value |
| pairDe | input | ADDR_W | Current DE value |
| pairHl | input | ADDR_W | Current HL value |
| stackPtr | input | ADDR_W | Current SP value |
| offset | input | OFF_W | Signed offset byte |
| resValid | output | 1 | Result valid pulse |
| result | output | ADDR_W | 16-bit result |
| resDest | output | 2 | Code of the pair that takes the result |
| zeroWe | output | 1 | Zero flag write enable |
| zeroVal | output | 1 | Zero flag value |
| subWe | output | 1 | Subtract flag write enable |
| subVal | output | 1 | Subtract flag value |
| halfWe | output | 1 | Half-carry flag write enable |
| halfVal | output | 1 | Half-carry flag value |
| carryWe | output | 1 | Carry flag write enable |
| carryVal | output | 1 | Carry flag value |

## Verification
The bench builds the unit with its default widths: a 16-bit address and an 8-bit offset. At these widths the wrap points 0xFFFF and 0x0000 are reached directly. So are the carries out of bit 3, bit 7, bit 11 and bit 15, with hand-picked operands. The offset cases cover the most negative byte, which gives a result with no low-byte carry. They also cover an offset of -1, which produces a low-byte carry while the 16-bit result goes down. Together these separate the unsigned low-byte carry from a carry out of the full 16-bit sum.

// File: rtl/arith16_pkg.sv
package arith16_pkg;

  typedef enum logic [2:0] {
    OP_INC       = 3'd0,
    OP_DEC       = 3'd1,
    OP_ADD_HL    = 3'd2,
    OP_SP_OFF    = 3'd3,
    OP_SP_OFF_HL = 3'd4
  } arith_op_e;

  localparam logic [1:0] PAIR_HL = 2'd2;
  localparam logic [1:0] PAIR_SP = 2'd3;

  // Flag vectors are ordered {zero, subtract, half, carry}.
  typedef struct packed {
    logic       act;
    logic       stepUp;
    logic       stepDown;
    logic       addPair;
    logic       addOff;
    logic [1:0] dest;
    logic [3:0] flagWe;
  } strobe_t;

endpackage

// File: rtl/arith16_ctrl.sv
module arith16_ctrl
  import arith16_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opSel,
  input  logic [1:0] pairCode,
  output strobe_t    strb
);

  always_comb begin
    strb = '0;
    if (opValid) begin
      case (opSel)
        OP_INC: begin
          strb.act    = 1'b1;
          strb.stepUp = 1'b1;
          strb.dest   = pairCode;
        end
        OP_DEC: begin
          strb.act      = 1'b1;
          strb.stepDown = 1'b1;
          strb.dest     = pairCode;
        end
        OP_ADD_HL: begin
          strb.act     = 1'b1;
          strb.addPair = 1'b1;
          strb.dest    = PAIR_HL;
          strb.flagWe  = 4'b0111;
        end
        OP_SP_OFF: begin
          strb.act    = 1'b1;
          strb.addOff = 1'b1;
          strb.dest   = PAIR_SP;
          strb.flagWe = 4'b1111;
        end
        OP_SP_OFF_HL: begin
          strb.act    = 1'b1;
          strb.addOff = 1'b1;
          strb.dest   = PAIR_HL;
          strb.flagWe = 4'b1111;
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/arith16_dp.sv
module arith16_dp
  import arith16_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  strobe_t             strb,
  input  logic [1:0]          pairCode,
  input  logic [ADDR_W-1:0]   pairBc,
  input  logic [ADDR_W-1:0]   pairDe,
  input  logic [ADDR_W-1:0]   pairHl,
  input  logic [ADDR_W-1:0]   stackPtr,
  input  logic [OFF_W-1:0]    offset,
  output logic [ADDR_W-1:0]   sum,
  output logic [3:0]          flagVal
);

  localparam int NUM_PAIRS = 4;
  localparam int HALF_W    = ADDR_W - 4;   // bits below the pair-add half carry
  localparam int EXT_W     = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] pairVals [NUM_PAIRS];
  logic [ADDR_W-1:0] srcVal;
  logic [ADDR_W:0]   wideSum;
  logic [HALF_W:0]   hlLowSum;
  logic [OFF_W:0]    byteSum;
  logic [4:0]        nibSum;
  logic [ADDR_W-1:0] offExt;

  assign pairVals[0] = pairBc;
  assign pairVals[1] = pairDe;
  assign pairVals[2] = pairHl;
  assign pairVals[3] = stackPtr;
  assign srcVal      = pairVals[pairCode];

  assign wideSum  = {1'b0, pairHl} + {1'b0, srcVal};
  assign hlLowSum = {1'b0, pairHl[HALF_W-1:0]} + {1'b0, srcVal[HALF_W-1:0]};
  assign offExt   = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign byteSum  = {1'b0, stackPtr[OFF_W-1:0]} + {1'b0, offset};
  assign nibSum   = {1'b0, stackPtr[3:0]} + {1'b0, offset[3:0]};

  always_comb begin
    sum     = '0;
    flagVal = '0;
    if (strb.stepUp) begin
      sum = srcVal + ADDR_W'(1);
    end else if (strb.stepDown) begin
      sum = srcVal - ADDR_W'(1);
    end else if (strb.addPair) begin
      sum     = wideSum[ADDR_W-1:0];
      flagVal = {1'b0, 1'b0, hlLowSum[HALF_W], wideSum[ADDR_W]};
    end else if (strb.addOff) begin
      sum     = stackPtr + offExt;
      flagVal = {1'b0, 1'b0, nibSum[4], byteSum[OFF_W]};
    end
  end

endmodule

// File: rtl/arith16_unit.sv
module arith16_unit
  import arith16_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [1:0]        pairCode,
  input  logic [ADDR_W-1:0] pairBc,
  input  logic [ADDR_W-1:0] pairDe,
  input  logic [ADDR_W-1:0] pairHl,
  input  logic [ADDR_W-1:0] stackPtr,
  input  logic [OFF_W-1:0]  offset,
  output logic              resValid,
  output logic [ADDR_W-1:0] result,
  output logic [1:0]        resDest,
  output logic              zeroWe,
  output logic              zeroVal,
  output logic              subWe,
  output logic              subVal,
  output logic              halfWe,
  output logic              halfVal,
  output logic              carryWe,
  output logic              carryVal
);

  strobe_t           strb;
  logic [ADDR_W-1:0] sum;
  logic [3:0]        flagVal;
  logic [3:0]        weQ;
  logic [3:0]        valQ;

  arith16_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .pairCode(pairCode),
    .strb    (strb)
  );

  arith16_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .strb    (strb),
    .pairCode(pairCode),
    .pairBc  (pairBc),
    .pairDe  (pairDe),
    .pairHl  (pairHl),
    .stackPtr(stackPtr),
    .offset  (offset),
    .sum     (sum),
    .flagVal (flagVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      resDest  <= '0;
      weQ      <= '0;
      valQ     <= '0;
    end else begin
      resValid <= strb.act;
      weQ      <= strb.flagWe;
      if (strb.act) begin
        result  <= sum;
        resDest <= strb.dest;
        valQ    <= flagVal;
      end
    end
  end

  assign {zeroWe, subWe, halfWe, carryWe}     = weQ;
  assign {zeroVal, subVal, halfVal, carryVal} = valQ;

endmodule

// File: rtl/arith16_chk.sv
module arith16_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opSel,
  input logic [1:0]        pairCode,
  input logic [ADDR_W-1:0] pairBc,
  input logic [ADDR_W-1:0] pairDe,
  input logic [ADDR_W-1:0] pairHl,
  input logic [ADDR_W-1:0] stackPtr,
  input logic              resValid,
  input logic [ADDR_W-1:0] result,
  input logic [1:0]        resDest,
  input logic              zeroWe,
  input logic              zeroVal,
  input logic              subWe,
  input logic              subVal,
  input logic              halfWe,
  input logic              carryWe
);

  logic [ADDR_W-1:0] pickPair;
  assign pickPair = (pairCode == 2'd0) ? pairBc :
                    (pairCode == 2'd1) ? pairDe :
                    (pairCode == 2'd2) ? pairHl : stackPtr;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel <= 3'd4) |=> resValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);

  assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd0) |=>
      (result == $past(pickPair) + ADDR_W'(1)) && (resDest == $past(pairCode)));

  assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd1) |=>
      (result == $past(pickPair) - ADDR_W'(1)) && (resDest == $past(pairCode)));

  assert_step_no_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel <= 3'd1) |=> !(zeroWe || subWe || halfWe || carryWe));

  assert_hl_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd2) |=> (resDest == 2'd2) && carryWe);

  assert_hl_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd2) |=> subWe && !subVal && halfWe && !zeroWe);

  assert_off_dest_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 3'd3 || opSel == 3'd4)) |=>
      (resDest == (($past(opSel) == 3'd3) ? 2'd3 : 2'd2)));

  assert_off_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 3'd3 || opSel == 3'd4)) |=>
      zeroWe && !zeroVal && subWe && !subVal && halfWe && carryWe);

  assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel > 3'd4) |=> !resValid);

endmodule

bind arith16_unit arith16_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
  .pairCode(pairCode), .pairBc(pairBc), .pairDe(pairDe), .pairHl(pairHl),
  .stackPtr(stackPtr), .resValid(resValid), .result(result),
  .resDest(resDest), .zeroWe(zeroWe), .zeroVal(zeroVal), .subWe(subWe),
  .subVal(subVal), .halfWe(halfWe), .carryWe(carryWe)
);

// File: tb/sim_arith16_unit.sv
module sim_arith16_unit;

  localparam int ADDR_W = 16;
  localparam int OFF_W  = 8;

  typedef struct {
    logic [15:0] res;
    logic [1:0]  dest;
    logic [3:0]  we;
    logic [3:0]  val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  pairCode = '0;
  logic [15:0] pairBc = '0, pairDe = '0, pairHl = '0, stackPtr = '0;
  logic [7:0]  offset = '0;
  logic        resValid;
  logic [15:0] result;
  logic [1:0]  resDest;
  logic        zeroWe, zeroVal, subWe, subVal, halfWe, halfVal, carryWe, carryVal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t expQ[$];

  always #5 clk = ~clk;

  arith16_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .pairCode(pairCode), .pairBc(pairBc), .pairDe(pairDe), .pairHl(pairHl),
    .stackPtr(stackPtr), .offset(offset), .resValid(resValid),
    .result(result), .resDest(resDest), .zeroWe(zeroWe), .zeroVal(zeroVal),
    .subWe(subWe), .subVal(subVal), .halfWe(halfWe), .halfVal(halfVal),
    .carryWe(carryWe), .carryVal(carryVal)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation at a falling edge and queues its expectation.
  task automatic drive(input logic [2:0] op, input logic [1:0] pc,
                       input logic [15:0] bc, input logic [15:0] de,
                       input logic [15:0] hl, input logic [15:0] sp,
                       input logic [7:0] off, input string tag);
    exp_t e;
    logic [15:0] src;
    logic [16:0] wide;
    logic [12:0] low12;
    logic [8:0]  bsum;
    logic [4:0]  nsum;
    @(negedge clk);
    opValid = 1'b1; opSel = op; pairCode = pc;
    pairBc = bc; pairDe = de; pairHl = hl; stackPtr = sp; offset = off;
    src = (pc == 2'd0) ? bc : (pc == 2'd1) ? de : (pc == 2'd2) ? hl : sp;
    e.tag = tag;
    e.we = 4'b0000; e.val = 4'b0000;
    case (op)
      3'd0: begin e.res = src + 16'd1; e.dest = pc; end
      3'd1: begin e.res = src - 16'd1; e.dest = pc; end
      3'd2: begin
        wide  = {1'b0, hl} + {1'b0, src};
        low12 = {1'b0, hl[11:0]} + {1'b0, src[11:0]};
        e.res = wide[15:0]; e.dest = 2'd2;
        e.we = 4'b0111; e.val = {1'b0, 1'b0, low12[12], wide[16]};
      end
      default: begin
        bsum = {1'b0, sp[7:0]} + {1'b0, off};
        nsum = {1'b0, sp[3:0]} + {1'b0, off[3:0]};
        e.res = sp + {{8{off[7]}}, off};
        e.dest = (op == 3'd3) ? 2'd3 : 2'd2;
        e.we = 4'b1111; e.val = {1'b0, 1'b0, nsum[4], bsum[8]};
      end
    endcase
    if (op <= 3'd4) expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected resValid", 32'(result), 32'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(result == e.res, {e.tag, " result"}, 32'(result), 32'(e.res));
        check(resDest == e.dest, {e.tag, " dest"}, 32'(resDest), 32'(e.dest));
        check({zeroWe, subWe, halfWe, carryWe} == e.we, {e.tag, " flag enables"},
              32'({zeroWe, subWe, halfWe, carryWe}), 32'(e.we));
        check((({zeroVal, subVal, halfVal, carryVal}) & e.we) == (e.val & e.we),
              {e.tag, " flag values"},
              32'({zeroVal, subVal, halfVal, carryVal} & e.we), 32'(e.val & e.we));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!resValid && result == 16'h0 && resDest == 2'd0 &&
          !(zeroWe || subWe || halfWe || carryWe), "R1 reset state",
          {resValid, zeroWe, subWe, halfWe, carryWe, 9'h0, result},
          32'h0);

    // R3 / R5 increment, including wrap
    drive(3'd0, 2'd0, 16'h1234, 16'h0, 16'h0, 16'h0, 8'h0, "R3 inc BC R5");
    drive(3'd0, 2'd1, 16'h0, 16'hFFFF, 16'h0, 16'h0, 8'h0, "R3 inc DE wrap");
    // R4 / R5 decrement, including wrap
    drive(3'd1, 2'd2, 16'h0, 16'h0, 16'h0000, 16'h0, 8'h0, "R4 dec HL wrap R5");
    drive(3'd1, 2'd3, 16'h0, 16'h0, 16'h0, 16'h8000, 8'h0, "R4 dec SP");
    idle();
    // R6 / R7 add pair to HL
    drive(3'd2, 2'd1, 16'h0, 16'h0FFF, 16'h0001, 16'h0, 8'h0, "R7 add DE half");
    drive(3'd2, 2'd3, 16'h0, 16'h0, 16'hFFFF, 16'h0001, 8'h0, "R6 add SP carry");
    drive(3'd2, 2'd2, 16'h0, 16'h0, 16'h8000, 16'h0, 8'h0, "R6 add HL HL carry");
    drive(3'd2, 2'd0, 16'h7000, 16'h0, 16'h0123, 16'h0, 8'h0, "R6 add BC none");
    idle();
    // R8 / R9 / R10 signed offset
    drive(3'd3, 2'd0, 16'h0, 16'h0, 16'h0, 16'h0000, 8'h80, "R8 sp-128 R10");
    drive(3'd3, 2'd0, 16'h0, 16'h0, 16'h0, 16'h00FF, 8'h01, "R9 sp+1 carry");
    drive(3'd4, 2'd0, 16'h0, 16'h0, 16'h0, 16'h1234, 8'hFF, "R9 sp-1 to HL");
    drive(3'd4, 2'd0, 16'h0, 16'h0, 16'h0, 16'hFFF8, 8'h08, "R10 zero result");
    idle();
    // R11 unrecognised codes
    for (int k = 5; k < 8; k++) begin
      drive(3'(k), 2'd0, 16'h1, 16'h2, 16'h3, 16'h4, 8'h5, "R11 bad op");
      idle();
      check(!resValid, "R11 no result pulse", 32'(resValid), 32'h0);
    end
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 all results seen", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule